// File: doc/BRIEF.md
# Host Register Port with Word-Lane Steering

This block is the host side of a peripheral's register interface. A host drives it with an asynchronous, strobe-based bus: active-low chip select, write and read strobes, a two-bit dword address and two active-low word-lane enables. Lane 0 covers bits 15:0 and lane 1 covers bits 31:16. The bus is 32 bits wide. It is split into a data input, a data output and a per-lane output enable, and a pad ring turns these into a bidirectional bus. The block decodes four direct registers. The first is a data port onto an external 32-bit FIFO, which pushes on writes and pops on reads. The second is an index register. The third is a 16-bit window onto an indirect register file, and its index steps forward after each access. The fourth is an error and status register.

All strobes, lanes and the address pass through a two-flop synchronizer into the internal clock. A lane's part in an access ends when that lane's enable rises or when the strobe rises, whichever comes first. That moment is the release of the lane. Writes take effect at the release, and pointers advance at the release. A 16-bit host can therefore move a FIFO entry as two halves, lower half first: the lower half waits in a staging register until the upper half completes. The read path is combinational from the pins, so the bus is driven for as long as select and read are held low.

Top module: `hostreg_port`

## Requirements
- R1: After reset no FIFO push, FIFO pop or window write is issued, `ind_idx` is 0, `host_data_oe` is 0 while the strobes are idle, and the status register reads 0 when the FIFO is neither full nor empty.
- R2: While `host_cs_n` is high, `host_data_oe` is 00 whatever the other pins do, and a write strobe has no effect.
- R3: While `host_cs_n` and `host_rd_n` are both low, `host_data_oe[i]` is 1 exactly when `host_lane_n[i]` is 0. A disabled lane outputs zeros. The address selects the source: 0 gives the FIFO head word, 1 gives the index zero-extended, 2 gives the indirect read data in bits 15:0 with the upper half zero, and 3 gives the status word. The status word has bit0 = underflow error, bit1 = overflow error, bit2 = FIFO empty and bit3 = FIFO full.
- R4: A write to address 0 with both lanes enabled pushes the whole 32-bit bus word exactly once, after the write strobe rises.
- R5: A write to address 0 with only lane 0 enabled stages bits 15:0 and does not push. A later write with only lane 1 enabled pushes {bits 31:16 of that write, the staged lower half}.
- R6: A write that releases lane 1 at address 0 while `fifo_full` is high does not push, and it sets the sticky overflow bit (status bit1).
- R7: A read at address 0 issues one pop when lane 1 is released. A read on lane 0 alone issues no pop. A lane-1 release while `fifo_empty` is high issues no pop and sets the sticky underflow bit (status bit0).
- R8: A write to address 1 with lane 0 enabled loads `ind_idx` from the low index bits of the bus.
- R9: An access to address 2 that releases lane 0 advances `ind_idx` by one, and the index wraps at its width. If the access is a write, it first issues one `ind_we` with the index before the step and bits 15:0 of the bus. An access on lane 1 alone neither writes nor advances.
- R10: The error bits stay set until a write to address 3 with lane 0 enabled. In that write, a 1 in bit0 clears underflow and a 1 in bit1 clears overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_wr_n | input | 1 | Write strobe, active low; write lands at its rise |
| host_rd_n | input | 1 | Read strobe, active low |
| host_adr | input | 2 | Direct register select |
| host_lane_n | input | 2 | Word-lane enables, active low; bit0 = bits 15:0, bit1 = bits 31:16 |
| host_data_i | input | 32 | Data from the host |
| host_data_o | output | 32 | Data to the host |
| host_data_oe | output | 2 | Per-lane output enable for the pad drivers |
| fifo_push | output | 1 | One-cycle push request |
| fifo_wdata | output | 32 | Word to push |
| fifo_full | input | 1 | FIFO cannot accept a word |
| fifo_pop | output | 1 | One-cycle pop request |
| fifo_rdata | input | 32 | FIFO head word |
| fifo_empty | input | 1 | FIFO has no word |
| ind_idx | output | 8 | Current indirect register index |
| ind_we | output | 1 | One-cycle write to the indirect register at `ind_idx` |
| ind_wdata | output | 16 | Data for the indirect write |
| ind_rdata | input | 16 | Indirect register contents at `ind_idx` |

## Verification
The assertions assume an orderly host. Select, address, lane enables and write data must stay stable from before a strobe falls until at least three clock cycles after the lane is released. Each strobe must stay low for at least two clock cycles, and write and read must never be low together. The assertions also assume the FIFO flags do not change during the cycle of a release. The bench's bus tasks keep within these rules. They set up select, address and lanes one cycle before the strobe, hold the strobe for three cycles, and keep everything for four cycles after the release. The FIFO flags and the indirect read data change only between accesses.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

    localparam int DATA_W  = 32;
    localparam int HALF_W  = DATA_W / 2;
    localparam int LANES   = 2;
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;

    typedef enum logic [1:0] {
        SEL_FIFO   = 2'd0,
        SEL_INDEX  = 2'd1,
        SEL_WINDOW = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    // One synchronized view of the host bus controls.
    typedef struct packed {
        logic           cs_n;
        logic           wr_n;
        logic           rd_n;
        logic [LANES-1:0] lane_n;
        logic [1:0]     adr;
    } bus_ctl_t;

    // Lane release event produced by the access tracker.
    typedef struct packed {
        logic [LANES-1:0] rel;
        logic             is_wr;
        reg_sel_e         sel;
    } host_evt_t;

    localparam bus_ctl_t CTL_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1,
                                      lane_n: '1, adr: 2'd0};

    function automatic logic [DATA_W-1:0] status_word(logic unf, logic ovf,
                                                       logic empty, logic full);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = unf;
        w[1] = ovf;
        w[2] = empty;
        w[3] = full;
        return w;
    endfunction

endpackage

// File: rtl/hostreg_sync.sv
module hostreg_sync #(
    parameter int          W       = 7,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hostreg_access.sv
module hostreg_access
    import hostreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_ctl_t  ctl,
    output host_evt_t evt
);
    logic             act;
    logic [LANES-1:0] lane_act;
    logic [LANES-1:0] lane_act_q;
    logic             is_wr_q;
    reg_sel_e         sel_q;

    assign act = !ctl.cs_n && (!ctl.wr_n || !ctl.rd_n);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_act[i] = act && !ctl.lane_n[i];
        assign evt.rel[i]  = lane_act_q[i] && !lane_act[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_act_q <= '0;
            is_wr_q    <= 1'b0;
            sel_q      <= SEL_FIFO;
        end else begin
            lane_act_q <= lane_act;
            if (act) begin
                is_wr_q <= !ctl.wr_n;
                sel_q   <= reg_sel_e'(ctl.adr);
            end
        end
    end

    assign evt.is_wr = is_wr_q;
    assign evt.sel   = sel_q;

    // A release can only follow a cycle in which that lane was active.
    p_rel_after_act_r4: assert property (@(posedge clk) disable iff (rst)
        evt.rel[LANE_HI] |-> $past(!ctl.cs_n && !ctl.lane_n[LANE_HI]));
endmodule

// File: rtl/hostreg_regs.sv
module hostreg_regs
    import hostreg_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  host_evt_t         evt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_pop,
    output logic [IDX_W-1:0]  ind_idx,
    output logic              ind_we,
    output logic [HALF_W-1:0] ind_wdata,
    output logic              err_unf,
    output logic              err_ovf
);
    logic              hit_fifo, hit_index, hit_window, hit_status;
    logic              hi_wr, hi_rd, lo_wr, win_step, stage_ld;
    logic [HALF_W-1:0] stage_lo;

    always_comb begin
        hit_fifo   = evt.sel == SEL_FIFO;
        hit_index  = evt.sel == SEL_INDEX;
        hit_window = evt.sel == SEL_WINDOW;
        hit_status = evt.sel == SEL_STATUS;
        hi_wr      = evt.rel[LANE_HI] &&  evt.is_wr;
        hi_rd      = evt.rel[LANE_HI] && !evt.is_wr;
        lo_wr      = evt.rel[LANE_LO] &&  evt.is_wr;
        stage_ld   = hit_fifo && lo_wr;
        win_step   = hit_window && evt.rel[LANE_LO];

        fifo_push  = hit_fifo && hi_wr && !fifo_full;
        fifo_wdata = {wdata[DATA_W-1:HALF_W],
                      evt.rel[LANE_LO] ? wdata[HALF_W-1:0] : stage_lo};
        fifo_pop   = hit_fifo && hi_rd && !fifo_empty;
        ind_we     = hit_window && lo_wr;
        ind_wdata  = wdata[HALF_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_lo <= '0;
            ind_idx  <= '0;
            err_unf  <= 1'b0;
            err_ovf  <= 1'b0;
        end else begin
            if (stage_ld) stage_lo <= wdata[HALF_W-1:0];

            if (hit_index && lo_wr) ind_idx <= wdata[IDX_W-1:0];
            else if (win_step)      ind_idx <= ind_idx + 1'b1;

            if (hit_fifo && hi_rd && fifo_empty)        err_unf <= 1'b1;
            else if (hit_status && lo_wr && wdata[0])   err_unf <= 1'b0;

            if (hit_fifo && hi_wr && fifo_full)         err_ovf <= 1'b1;
            else if (hit_status && lo_wr && wdata[1])   err_ovf <= 1'b0;
        end
    end

    p_push_not_full_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> !fifo_full);
    p_pop_not_empty_r7: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !fifo_empty);
    p_push_pop_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(fifo_push && fifo_pop));
    p_idx_step_r9: assert property (@(posedge clk) disable iff (rst)
        ind_we |=> ind_idx == $past(ind_idx) + 1'b1);
    p_unf_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(err_unf) |-> $past(evt.rel[LANE_LO] && evt.is_wr && evt.sel == SEL_STATUS));
    p_ovf_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(err_ovf) |-> $past(evt.rel[LANE_LO] && evt.is_wr && evt.sel == SEL_STATUS));
endmodule

// File: rtl/hostreg_rdmux.sv
module hostreg_rdmux
    import hostreg_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [1:0]        adr,
    input  logic [LANES-1:0]  lane_n,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  logic [IDX_W-1:0]  ind_idx,
    input  logic [HALF_W-1:0] ind_rdata,
    input  logic              err_unf,
    input  logic              err_ovf,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    output logic [DATA_W-1:0] data_o,
    output logic [LANES-1:0]  data_oe
);
    logic [DATA_W-1:0] word;

    always_comb begin
        word = '0;
        unique case (reg_sel_e'(adr))
            SEL_FIFO:   word = fifo_rdata;
            SEL_INDEX:  word[IDX_W-1:0] = ind_idx;
            SEL_WINDOW: word[HALF_W-1:0] = ind_rdata;
            SEL_STATUS: word = status_word(err_unf, err_ovf, fifo_empty, fifo_full);
            default:    word = '0;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign data_oe[i] = !cs_n && !rd_n && !lane_n[i];
        assign data_o[i*HALF_W +: HALF_W] = data_oe[i] ? word[i*HALF_W +: HALF_W] : '0;
    end
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
    import hostreg_pkg::*;
#(
    parameter int IDX_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs_n,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic [1:0]        host_adr,
    input  logic [1:0]        host_lane_n,
    input  logic [31:0]       host_data_i,
    output logic [31:0]       host_data_o,
    output logic [1:0]        host_data_oe,
    output logic              fifo_push,
    output logic [31:0]       fifo_wdata,
    input  logic              fifo_full,
    output logic              fifo_pop,
    input  logic [31:0]       fifo_rdata,
    input  logic              fifo_empty,
    output logic [IDX_W-1:0]  ind_idx,
    output logic              ind_we,
    output logic [15:0]       ind_wdata,
    input  logic [15:0]       ind_rdata
);
    localparam int CTL_W = $bits(bus_ctl_t);

    bus_ctl_t  ctl_raw, ctl_s;
    host_evt_t evt;
    logic      err_unf, err_ovf;

    assign ctl_raw = '{cs_n: host_cs_n, wr_n: host_wr_n, rd_n: host_rd_n,
                       lane_n: host_lane_n, adr: host_adr};

    hostreg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    hostreg_access u_access (
        .clk (clk),
        .rst (rst),
        .ctl (ctl_s),
        .evt (evt)
    );

    hostreg_regs #(.IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .wdata      (host_data_i),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .fifo_push  (fifo_push),
        .fifo_wdata (fifo_wdata),
        .fifo_pop   (fifo_pop),
        .ind_idx    (ind_idx),
        .ind_we     (ind_we),
        .ind_wdata  (ind_wdata),
        .err_unf    (err_unf),
        .err_ovf    (err_ovf)
    );

    hostreg_rdmux #(.IDX_W(IDX_W)) u_rdmux (
        .cs_n       (host_cs_n),
        .rd_n       (host_rd_n),
        .adr        (host_adr),
        .lane_n     (host_lane_n),
        .fifo_rdata (fifo_rdata),
        .ind_idx    (ind_idx),
        .ind_rdata  (ind_rdata),
        .err_unf    (err_unf),
        .err_ovf    (err_ovf),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .data_o     (host_data_o),
        .data_oe    (host_data_oe)
    );

    // With select held high for the whole sync delay, no lane can release.
    p_no_event_deselected_r2: assert property (@(posedge clk) disable iff (rst)
        $past(host_cs_n, SYNC_STAGES + 1) && $past(host_cs_n, SYNC_STAGES)
        |-> !fifo_push && !fifo_pop && !ind_we);
endmodule

// File: tb/hostreg_port_tb_top.sv
module hostreg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs_n = 1'b1, host_wr_n = 1'b1, host_rd_n = 1'b1;
    logic [1:0]  host_adr = 2'd0, host_lane_n = 2'b11;
    logic [31:0] host_data_i = '0;
    logic [31:0] host_data_o;
    logic [1:0]  host_data_oe;
    logic        fifo_push, fifo_pop, ind_we;
    logic [31:0] fifo_wdata;
    logic        fifo_full = 1'b0, fifo_empty = 1'b0;
    logic [31:0] fifo_rdata = 32'hA5A5_1234;
    logic [7:0]  ind_idx;
    logic [15:0] ind_wdata;
    logic [15:0] ind_rdata = 16'h5A5A;

    int checks = 0, errors = 0;
    int push_seen = 0, pop_seen = 0, we_seen = 0;
    bit done = 0;
    logic [31:0] exp_push_q [$];
    logic [23:0] exp_we_q [$];

    always #5 clk = ~clk;

    hostreg_port dut_i (
        .clk(clk), .rst(rst),
        .host_cs_n(host_cs_n), .host_wr_n(host_wr_n), .host_rd_n(host_rd_n),
        .host_adr(host_adr), .host_lane_n(host_lane_n),
        .host_data_i(host_data_i), .host_data_o(host_data_o), .host_data_oe(host_data_oe),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
        .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
        .ind_idx(ind_idx), .ind_we(ind_we), .ind_wdata(ind_wdata), .ind_rdata(ind_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compares side-effect pulses against expected queues.
    always @(negedge clk) begin
        if (!rst && fifo_push) begin
            push_seen++;
            if (exp_push_q.size() == 0) check(1'b0, "R4 unexpected push", fifo_wdata, 32'h0);
            else begin
                logic [31:0] e;
                e = exp_push_q.pop_front();
                check(fifo_wdata == e, "R4/R5 push word", fifo_wdata, e);
            end
        end
        if (!rst && fifo_pop) pop_seen++;
        if (!rst && ind_we) begin
            we_seen++;
            if (exp_we_q.size() == 0) check(1'b0, "R9 unexpected window write",
                                            {8'h0, ind_idx, ind_wdata}, 32'h0);
            else begin
                logic [23:0] e;
                e = exp_we_q.pop_front();
                check({ind_idx, ind_wdata} == e, "R9 window write",
                      {8'h0, ind_idx, ind_wdata}, {8'h0, e});
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [1:0] adr, input logic [1:0] lane_n,
                             input logic [31:0] d);
        settle(1);
        host_cs_n = 1'b0; host_adr = adr; host_lane_n = lane_n; host_data_i = d;
        settle(1);
        host_wr_n = 1'b0;
        settle(3);
        host_wr_n = 1'b1;
        settle(4);
        host_cs_n = 1'b1; host_lane_n = 2'b11;
        settle(2);
    endtask

    task automatic bus_read(input logic [1:0] adr, input logic [1:0] lane_n,
                            input logic [31:0] exp, input string req);
        settle(1);
        host_cs_n = 1'b0; host_adr = adr; host_lane_n = lane_n;
        settle(1);
        host_rd_n = 1'b0;
        settle(2);
        @(negedge clk);
        check(host_data_o == exp, req, host_data_o, exp);
        check(host_data_oe == ~lane_n, {req, " (R3 lane enables)"},
              {30'h0, host_data_oe}, {30'h0, ~lane_n});
        settle(1);
        host_rd_n = 1'b1;
        settle(4);
        host_cs_n = 1'b1; host_lane_n = 2'b11;
        settle(2);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 32'h0, 32'h0);
            finish_run();
        end
    end

    initial begin
        settle(4);
        rst = 1'b0;
        settle(3);
        @(negedge clk);
        // R1: reset state
        check(ind_idx == 8'h00, "R1 index after reset", {24'h0, ind_idx}, 32'h0);
        check(host_data_oe == 2'b00, "R1 bus idle", {30'h0, host_data_oe}, 32'h0);
        check(!fifo_push && !fifo_pop && !ind_we, "R1 no pulses",
              {29'h0, fifo_push, fifo_pop, ind_we}, 32'h0);
        bus_read(2'd3, 2'b00, 32'h0, "R1/R3 status after reset");

        // R2: deselected read and write
        settle(1);
        host_rd_n = 1'b0;
        settle(2);
        @(negedge clk);
        check(host_data_oe == 2'b00, "R2 no drive when deselected",
              {30'h0, host_data_oe}, 32'h0);
        settle(1);
        host_rd_n = 1'b1;
        host_lane_n = 2'b00; host_data_i = 32'hFFFF_0000;
        host_wr_n = 1'b0;
        settle(3);
        host_wr_n = 1'b1;
        settle(5);
        host_lane_n = 2'b11;
        check(push_seen == 0, "R2 deselected write ignored", push_seen, 0);

        // R4: full-width push
        exp_push_q.push_back(32'hDEAD_BEEF);
        bus_write(2'd0, 2'b00, 32'hDEAD_BEEF);
        check(push_seen == 1, "R4 one push", push_seen, 1);

        // R5: split transfer, lower half first
        bus_write(2'd0, 2'b10, 32'h1111_2222);
        check(push_seen == 1, "R5 lower half staged only", push_seen, 1);
        exp_push_q.push_back(32'h3333_2222);
        bus_write(2'd0, 2'b01, 32'h3333_4444);
        check(push_seen == 2, "R5 upper half pushes", push_seen, 2);

        // R6: overflow
        fifo_full = 1'b1;
        bus_write(2'd0, 2'b00, 32'h7777_8888);
        check(push_seen == 2, "R6 no push when full", push_seen, 2);
        bus_read(2'd3, 2'b00, 32'h0000_000A, "R6 overflow flag");
        fifo_full = 1'b0;
        // R10: sticky, then cleared by writing bit1
        bus_read(2'd3, 2'b00, 32'h0000_0002, "R10 overflow sticky");
        bus_write(2'd3, 2'b00, 32'h0000_0002);
        bus_read(2'd3, 2'b00, 32'h0000_0000, "R10 overflow cleared");

        // R7: pops
        bus_read(2'd0, 2'b00, 32'hA5A5_1234, "R3 FIFO head read");
        check(pop_seen == 1, "R7 pop on full read", pop_seen, 1);
        bus_read(2'd0, 2'b10, 32'h0000_1234, "R3 lower lane only read");
        check(pop_seen == 1, "R7 no pop on lower lane", pop_seen, 1);
        bus_read(2'd0, 2'b01, 32'hA5A5_0000, "R3 upper lane only read");
        check(pop_seen == 2, "R7 pop on upper lane release", pop_seen, 2);
        fifo_empty = 1'b1;
        bus_read(2'd0, 2'b00, 32'hA5A5_1234, "R7 read while empty");
        check(pop_seen == 2, "R7 no pop when empty", pop_seen, 2);
        bus_read(2'd3, 2'b00, 32'h0000_0005, "R7 underflow flag");
        bus_write(2'd3, 2'b00, 32'h0000_0001);
        bus_read(2'd3, 2'b00, 32'h0000_0004, "R10 underflow cleared");
        fifo_empty = 1'b0;

        // R8: index load
        bus_write(2'd1, 2'b00, 32'h0000_0040);
        check(ind_idx == 8'h40, "R8 index loaded", {24'h0, ind_idx}, 32'h40);
        bus_read(2'd1, 2'b00, 32'h0000_0040, "R8 index readback");

        // R9: window write, read, lane 1 only, wrap
        exp_we_q.push_back({8'h40, 16'hBEEF});
        bus_write(2'd2, 2'b00, 32'h9999_BEEF);
        check(ind_idx == 8'h41, "R9 advance after write", {24'h0, ind_idx}, 32'h41);
        bus_read(2'd2, 2'b10, 32'h0000_5A5A, "R9 window read");
        check(ind_idx == 8'h42, "R9 advance after read", {24'h0, ind_idx}, 32'h42);
        bus_write(2'd2, 2'b01, 32'h1234_5678);
        check(ind_idx == 8'h42 && we_seen == 1, "R9 upper lane only ignored",
              {16'h0, we_seen[7:0], ind_idx}, {16'h0, 8'h01, 8'h42});
        bus_write(2'd1, 2'b00, 32'h0000_00FF);
        exp_we_q.push_back({8'hFF, 16'h0102});
        bus_write(2'd2, 2'b10, 32'h0000_0102);
        check(ind_idx == 8'h00, "R9 index wraps", {24'h0, ind_idx}, 32'h0);

        check(exp_push_q.size() == 0 && exp_we_q.size() == 0, "R4/R9 all expected pulses seen",
              exp_push_q.size() + exp_we_q.size(), 0);
        finish_run();
    end
endmodule